// File: doc/BRIEF.md
# Conservative Load/Store Ordering Queue

This block keeps every memory instruction that is in flight in one circular queue, in program order. An entry is claimed at dispatch, at the tail. It is released at retirement, from the head. Each entry learns its address later, from an address-generation port. Those writes come in whatever order the register dataflow delivers them, so they can name any live entry. Stores carry their data from dispatch. They stay parked until they retire, and at that point the queue presents them as a memory write.

An age-qualified comparator matrix compares every entry against every other. A load becomes eligible to go to memory only when three things hold: its own address is known, every store ahead of it in program order has a known address, and none of those addresses equals the load's address. Among the eligible loads, the one nearest the head is offered each cycle, and it is marked as issued at that clock edge. A flush input discards all entries. Address translation, the cache, store-to-load data forwarding and speculative issue are handled elsewhere.

Top module: `ldsq_order_q`

## Requirements
- R1: After reset the queue reports `empty`=1 and `full`=0, and no load is offered for issue.
- R2: A dispatch is written at the tail, and `disp_idx` shows the slot it takes. Slots are used in ring order and wrap from DEPTH-1 to 0. `full` rises after DEPTH live entries, and a dispatch while `full` is set is dropped.
- R3: A load with a known address and no older store is offered on `ld_issue_valid`/`ld_issue_idx`/`ld_issue_addr` in the cycle after its address is written. After the clock edge where it is offered, it is never offered again.
- R4: A load is held back while any older store in the queue has no address yet.
- R5: A load is held back while an older store holds an equal address, with all address bits compared. Older stores with different addresses do not hold it back, and neither do younger stores of any address.
- R6: When several loads are eligible, the one with the smallest distance from the head (modulo DEPTH) is offered.
- R7: `head_done` is 1 when the queue is not empty and the head entry has an address and is either a store or an issued load. `retire_en` frees the head only when `head_done` is 1, and is ignored otherwise. A retiring store drives `st_wr_valid` with its address and data in that same cycle.
- R8: `flush` empties the queue by the next cycle. A dispatch or retirement in the same cycle as the flush is discarded.
- R9: An address write to a slot that holds no live entry is ignored. A load later dispatched into that slot waits for its own address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all entries |
| disp_valid | input | 1 | Dispatch request |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_data | input | DW | Store data (unused for loads) |
| disp_idx | output | log2(DEPTH) | Slot a dispatch this cycle takes |
| agen_valid | input | 1 | Address write strobe |
| agen_idx | input | log2(DEPTH) | Slot receiving the address |
| agen_addr | input | AW | Address value |
| ld_issue_valid | output | 1 | A load is offered to memory |
| ld_issue_idx | output | log2(DEPTH) | Slot of the offered load |
| ld_issue_addr | output | AW | Address of the offered load |
| retire_en | input | 1 | Retire the head entry |
| head_done | output | 1 | Head entry may retire |
| st_wr_valid | output | 1 | A store is retiring this cycle |
| st_wr_addr | output | AW | Address of the retiring store |
| st_wr_data | output | DW | Data of the retiring store |
| full | output | 1 | DEPTH entries live |
| empty | output | 1 | No entries live |

## Verification
The checker verifies on every cycle the properties that hold locally. `full` and `empty` are never both set. A full queue stays full unless something leaves it. Nothing is offered while the queue is empty. A load is never offered twice in a row. A store write appears only during an accepted retirement. A flush always leaves the queue empty. Whether the right load is held back or released, which depends on older store addresses, unknown addresses and age with wraparound, can only be judged against the bench's reference model. The bench runs directed sequences that separate unknown-address blocking, equal-address blocking, unrelated stores and stale address writes, and then a long random mix over a small address pool that forces collisions.

// File: rtl/ldsq_pkg.sv
package ldsq_pkg;
   typedef enum logic {
      KIND_LOAD  = 1'b0,
      KIND_STORE = 1'b1
   } mem_kind_e;
endpackage

// File: rtl/ldsq_ring_ptrs.sv
module ldsq_ring_ptrs #(
   parameter int DEPTH = 8,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic          pop,
   output logic [IW-1:0] head,
   output logic [IW-1:0] tail,
   output logic          full,
   output logic          empty
);
   logic [IW:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         tail  <= head;
         cnt_q <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + 1'b1;
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign full  = (cnt_q == (IW+1)'(DEPTH));
   assign empty = (cnt_q == '0);
endmodule

// File: rtl/ldsq_dep_matrix.sv
module ldsq_dep_matrix #(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic [IW-1:0]    head,
   input  logic [DEPTH-1:0] live,
   input  logic [DEPTH-1:0] is_st,
   input  logic [DEPTH-1:0] has_addr,
   input  logic [AW-1:0]    addr [DEPTH],
   output logic [DEPTH-1:0] blocked
);
   logic [IW-1:0]    age [DEPTH];
   logic [DEPTH-1:0] hit [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_age
      assign age[i] = IW'(i) - head;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      for (genvar j = 0; j < DEPTH; j++) begin : g_col
         if (i == j) begin : g_diag
            assign hit[i][j] = 1'b0;
         end else begin : g_cmp
            assign hit[i][j] = live[j] && is_st[j] && (age[j] < age[i]) &&
                               (!has_addr[j] || (addr[j] == addr[i]));
         end
      end
      assign blocked[i] = |hit[i];
   end
endmodule

// File: rtl/ldsq_oldest_pick.sv
module ldsq_oldest_pick #(
   parameter int DEPTH = 8,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic [IW-1:0]    head,
   input  logic [DEPTH-1:0] req,
   output logic             found,
   output logic [IW-1:0]    idx
);
   always_comb begin
      logic [IW-1:0] p;
      found = 1'b0;
      idx   = '0;
      for (int k = 0; k < DEPTH; k++) begin
         p = head + IW'(k);
         if (!found && req[p]) begin
            found = 1'b1;
            idx   = p;
         end
      end
   end
endmodule

// File: rtl/ldsq_order_q.sv
module ldsq_order_q
   import ldsq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          disp_valid,
   input  logic          disp_is_store,
   input  logic [DW-1:0] disp_data,
   output logic [IW-1:0] disp_idx,
   input  logic          agen_valid,
   input  logic [IW-1:0] agen_idx,
   input  logic [AW-1:0] agen_addr,
   output logic          ld_issue_valid,
   output logic [IW-1:0] ld_issue_idx,
   output logic [AW-1:0] ld_issue_addr,
   input  logic          retire_en,
   output logic          head_done,
   output logic          st_wr_valid,
   output logic [AW-1:0] st_wr_addr,
   output logic [DW-1:0] st_wr_data,
   output logic          full,
   output logic          empty
);
   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 2");
      assert (AW >= 1 && DW >= 1)
         else $error("AW and DW must be positive");
   end

   logic [DEPTH-1:0] live_q, st_q, av_q, iss_q;
   logic [AW-1:0]    addr_q [DEPTH];
   logic [DW-1:0]    data_q [DEPTH];
   logic [IW-1:0]    head, tail;
   logic [DEPTH-1:0] blocked, eligible;
   logic             push, pop;

   assign head_done = !empty && av_q[head] && (st_q[head] || iss_q[head]);
   assign pop       = retire_en && head_done && !flush;
   assign push      = disp_valid && !full && !flush;
   assign disp_idx  = tail;

   ldsq_ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .clear(flush), .push(push), .pop(pop),
      .head(head), .tail(tail), .full(full), .empty(empty)
   );

   ldsq_dep_matrix #(.DEPTH(DEPTH), .AW(AW)) u_matrix (
      .head(head), .live(live_q), .is_st(st_q), .has_addr(av_q),
      .addr(addr_q), .blocked(blocked)
   );

   assign eligible = live_q & ~st_q & av_q & ~iss_q & ~blocked;

   ldsq_oldest_pick #(.DEPTH(DEPTH)) u_pick (
      .head(head), .req(eligible), .found(ld_issue_valid), .idx(ld_issue_idx)
   );

   assign ld_issue_addr = addr_q[ld_issue_idx];
   assign st_wr_valid   = pop && (st_q[head] == KIND_STORE);
   assign st_wr_addr    = addr_q[head];
   assign st_wr_data    = data_q[head];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
         st_q   <= '0;
         av_q   <= '0;
         iss_q  <= '0;
      end else if (flush) begin
         live_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (agen_valid && agen_idx == IW'(i) && live_q[i]) av_q[i] <= 1'b1;
            if (ld_issue_valid && ld_issue_idx == IW'(i))      iss_q[i] <= 1'b1;
            if (pop && head == IW'(i))                         live_q[i] <= 1'b0;
            if (push && tail == IW'(i)) begin
               live_q[i] <= 1'b1;
               st_q[i]   <= disp_is_store;
               av_q[i]   <= 1'b0;
               iss_q[i]  <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (agen_valid && agen_idx == IW'(i) && live_q[i]) addr_q[i] <= agen_addr;
         if (push && tail == IW'(i))                        data_q[i] <= disp_data;
      end
   end
endmodule

// File: rtl/ldsq_order_chk.sv
module ldsq_order_chk #(
   parameter int DEPTH = 8,
   localparam int IW = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          flush,
   input logic          retire_en,
   input logic          head_done,
   input logic          ld_issue_valid,
   input logic [IW-1:0] ld_issue_idx,
   input logic          st_wr_valid,
   input logic          full,
   input logic          empty
);
   p_full_empty_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !flush && !(retire_en && head_done)) |=> full);

   p_no_issue_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !ld_issue_valid);

   p_issue_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_issue_valid && !flush) |=>
         !(ld_issue_valid && ld_issue_idx == $past(ld_issue_idx)));

   p_store_on_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr_valid |-> (retire_en && head_done && !flush));

   p_done_needs_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      head_done |-> !empty);

   p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
endmodule

bind ldsq_order_q ldsq_order_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .retire_en(retire_en),
   .head_done(head_done), .ld_issue_valid(ld_issue_valid),
   .ld_issue_idx(ld_issue_idx), .st_wr_valid(st_wr_valid),
   .full(full), .empty(empty)
);

// File: tb/ldsq_order_q_test.sv
`timescale 1ns/1ps
module ldsq_order_q_test;
   localparam int D  = 8;
   localparam int IW = 3;
   localparam int AW = 32;
   localparam int DW = 32;

   logic clk = 0, rst_n = 0, flush = 0;
   logic disp_valid = 0, disp_is_store = 0;
   logic [DW-1:0] disp_data = '0;
   logic [IW-1:0] disp_idx;
   logic agen_valid = 0;
   logic [IW-1:0] agen_idx = '0;
   logic [AW-1:0] agen_addr = '0;
   logic ld_issue_valid;
   logic [IW-1:0] ld_issue_idx;
   logic [AW-1:0] ld_issue_addr;
   logic retire_en = 0, head_done, st_wr_valid, full, empty;
   logic [AW-1:0] st_wr_addr;
   logic [DW-1:0] st_wr_data;

   always #2 clk = ~clk;

   ldsq_order_q #(.DEPTH(D), .AW(AW), .DW(DW)) uut (.*);

   int checks = 0, errors = 0;
   bit done = 0;

   // reference model state
   bit m_live [D], m_st [D], m_av [D], m_iss [D];
   logic [AW-1:0] m_addr [D];
   logic [DW-1:0] m_data [D];
   int m_head = 0, m_tail = 0, m_cnt = 0;

   task automatic chk(input bit ok, input string tg, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, exp);
      end
   endtask

   // walk from head: a load is eligible when no earlier store lacks an
   // address and no earlier store holds the same address
   function automatic void exp_pick(output bit f, output int idx);
      bit unk = 0;
      f = 0; idx = 0;
      for (int k = 0; k < m_cnt; k++) begin
         int p = (m_head + k) % D;
         if (m_st[p]) begin
            if (!m_av[p]) unk = 1;
         end else if (!f && m_av[p] && !m_iss[p] && !unk) begin
            bit clash = 0;
            for (int k2 = 0; k2 < k; k2++) begin
               int q = (m_head + k2) % D;
               if (m_st[q] && m_addr[q] == m_addr[p]) clash = 1;
            end
            if (!clash) begin f = 1; idx = p; end
         end
      end
   endfunction

   task automatic step(input bit dv, input bit ds, input logic [DW-1:0] dd,
                       input bit av, input int ai, input logic [AW-1:0] aa,
                       input bit re, input bit fl, input string tg);
      bit ef; int ei; bit ehd, efull, eempty, pop, push;
      @(negedge clk);
      disp_valid = dv; disp_is_store = ds; disp_data = dd;
      agen_valid = av; agen_idx = IW'(ai); agen_addr = aa;
      retire_en = re; flush = fl;
      #1;
      exp_pick(ef, ei);
      ehd    = (m_cnt > 0) && m_av[m_head] && (m_st[m_head] || m_iss[m_head]);
      efull  = (m_cnt == D);
      eempty = (m_cnt == 0);
      pop    = re && ehd && !fl;
      push   = dv && !efull && !fl;
      chk(empty == eempty, {tg, "/R2"}, "empty", 64'(empty), 64'(eempty));
      chk(full == efull, {tg, "/R2"}, "full", 64'(full), 64'(efull));
      chk(ld_issue_valid == ef, {tg, "/R6"}, "ld_issue_valid",
          64'(ld_issue_valid), 64'(ef));
      if (ef && ld_issue_valid) begin
         chk(ld_issue_idx == IW'(ei), {tg, "/R6"}, "ld_issue_idx",
             64'(ld_issue_idx), 64'(ei));
         chk(ld_issue_addr == m_addr[ei], {tg, "/R3"}, "ld_issue_addr",
             64'(ld_issue_addr), 64'(m_addr[ei]));
      end
      chk(head_done == ehd, {tg, "/R7"}, "head_done", 64'(head_done), 64'(ehd));
      chk(st_wr_valid == (pop && m_st[m_head]), {tg, "/R7"}, "st_wr_valid",
          64'(st_wr_valid), 64'(pop && m_st[m_head]));
      if (pop && m_st[m_head]) begin
         chk(st_wr_addr == m_addr[m_head], {tg, "/R7"}, "st_wr_addr",
             64'(st_wr_addr), 64'(m_addr[m_head]));
         chk(st_wr_data == m_data[m_head], {tg, "/R7"}, "st_wr_data",
             64'(st_wr_data), 64'(m_data[m_head]));
      end
      if (push)
         chk(disp_idx == IW'(m_tail), {tg, "/R2"}, "disp_idx",
             64'(disp_idx), 64'(m_tail));
      // model next state
      if (fl) begin
         for (int i = 0; i < D; i++) m_live[i] = 0;
         m_tail = m_head; m_cnt = 0;
      end else begin
         if (av && m_live[ai]) begin m_av[ai] = 1; m_addr[ai] = aa; end
         if (ef) m_iss[ei] = 1;
         if (pop) begin m_live[m_head] = 0; m_head = (m_head + 1) % D; m_cnt--; end
         if (push) begin
            m_live[m_tail] = 1; m_st[m_tail] = ds; m_av[m_tail] = 0;
            m_iss[m_tail] = 0; m_data[m_tail] = dd;
            m_tail = (m_tail + 1) % D; m_cnt++;
         end
      end
   endtask

   task automatic idle(input string tg);
      step(0, 0, '0, 0, 0, '0, 0, 0, tg);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired R1 actual=hang expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < D; i++) begin
         m_live[i] = 0; m_st[i] = 0; m_av[i] = 0; m_iss[i] = 0;
         m_addr[i] = '0; m_data[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(empty == 1'b1, "R1", "empty", 64'(empty), 64'd1);
      chk(full == 1'b0, "R1", "full", 64'(full), 64'd0);
      chk(ld_issue_valid == 1'b0, "R1", "ld_issue_valid", 64'(ld_issue_valid), 64'd0);
      rst_n = 1;

      // store 0, loads 1 and 2
      step(1, 1, 32'hD00D, 0, 0, '0, 0, 0, "R2");
      step(1, 0, '0, 0, 0, '0, 0, 0, "R2");
      step(1, 0, '0, 0, 0, '0, 0, 0, "R2");
      // R4: load 1 address known, older store address unknown
      step(0, 0, '0, 1, 1, 32'h100, 0, 0, "R4");
      idle("R4");
      // R5: store gets same address; load 2 gets a different one
      step(0, 0, '0, 1, 0, 32'h100, 0, 0, "R5");
      step(0, 0, '0, 1, 2, 32'h200, 0, 0, "R5");
      idle("R5");
      idle("R3");
      // R7: store retires and writes, then load 1 is released
      step(0, 0, '0, 0, 0, '0, 1, 0, "R7");
      idle("R6");
      step(0, 0, '0, 0, 0, '0, 1, 0, "R7");
      step(0, 0, '0, 0, 0, '0, 1, 0, "R7");
      step(0, 0, '0, 0, 0, '0, 1, 0, "R7");
      // R9: address write to a free slot, then a load dispatched there
      step(0, 0, '0, 1, 3, 32'h300, 0, 0, "R9");
      step(1, 0, '0, 0, 0, '0, 0, 0, "R9");
      idle("R9");
      step(0, 0, '0, 1, 3, 32'h300, 0, 0, "R3");
      idle("R3");
      // R2: fill past full, then R8 flush with dispatch same cycle
      for (int i = 0; i < D + 2; i++) step(1, i[0], 32'(i), 0, 0, '0, 0, 0, "R2");
      step(1, 0, '0, 0, 0, '0, 1, 1, "R8");
      idle("R8");

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         bit dv, ds, av, re, fl, ehd; int ai, nc; int cand [D];
         dv = ($urandom % 3) != 0;
         ds = ($urandom % 2) == 1;
         nc = 0;
         for (int i = 0; i < D; i++)
            if (m_live[i] && !m_av[i]) begin cand[nc] = i; nc++; end
         av = ($urandom % 2) == 1;
         if (nc > 0 && ($urandom % 8) != 0) ai = cand[$urandom % nc];
         else ai = $urandom % D;
         ehd = (m_cnt > 0) && m_av[m_head] && (m_st[m_head] || m_iss[m_head]);
         re = ehd ? (($urandom % 2) == 1) : (($urandom % 8) == 0);
         fl = ($urandom % 100) == 0;
         step(dv, ds, $urandom, av, ai, 32'h40 * ($urandom % 4), re, fl, "RND");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule